// File: doc/BRIEF.md
# I2C Pointer-Addressed Read-Only Byte Target

This block is an I2C target that gives a bus master read access to a 256-byte storage array. It keeps an address pointer between transactions. A write transaction that carries one byte after the target address loads that byte into the pointer. A read transaction returns the byte at the pointer. The master can acknowledge each byte to continue the burst, and the pointer steps forward after every byte sent. To read from any location, the master writes the byte address and then, without a stop, issues a repeated start and reads. A read that has no preceding address write continues from wherever the pointer was left.

The bus pins are open-drain. The block takes the sampled SCL and SDA levels and returns one enable that pulls SDA low. Everything runs on the system clock. SCL and SDA pass through two-flop synchronisers, and the start, stop and SCL edge events come from the synchronised levels. The array has no write path. Its contents are computed from the address, which the read port registers one cycle after the pointer.

The controller has eight states:

| State | Role |
|---|---|
| IDLE | Wait for a start. |
| ADDR | Shift in the target address and the direction bit. |
| ADDR_ACK | Hold SDA low for the acknowledge. |
| PTR | Shift in the byte address. |
| PTR_ACK | Acknowledge the byte address. |
| TX | Shift a data byte out. |
| TX_ACK | Sample the master's answer to a data byte. |
| IGNORE | Stay off the bus. |

Transitions:

- A stop in any state goes to IDLE.
- A start or repeated start in any state goes to ADDR.
- ADDR goes to ADDR_ACK on the falling SCL edge after eight bits when the address matches, and to IGNORE when it does not.
- ADDR_ACK goes to TX when the direction bit is 1, or to PTR when it is 0. This happens on the falling edge that ends the acknowledge.
- PTR goes to PTR_ACK after eight bits.
- PTR_ACK goes to IGNORE.
- TX goes to TX_ACK after the eighth bit has been driven.
- TX_ACK goes back to TX when the master acknowledged, or to IGNORE when it did not.

Top module: `i2c_ptr_mem_target`

## Requirements
- R1: After reset SDA is released and the pointer is 0x00, so a first current-address read returns the byte of address 0x00.
- R2: A received target address whose upper 7 bits equal the configured address (default 0x50) is acknowledged by driving SDA low for the 9th clock. A mismatching address is not acknowledged, and the block drives nothing until the next start or repeated start.
- R3: In a write transaction (direction bit 0), the byte that follows the target address is acknowledged and loads the pointer.
- R4: In a read transaction (direction bit 1), the block shifts out the byte at the pointer after the address acknowledge, most significant bit first. A 0 bit is sent by driving SDA low and a 1 bit by releasing it.
- R5: When the master acknowledges a data byte (SDA low on the 9th clock), the next SCL pulses carry the byte from the following address.
- R6: The pointer advances by one for each byte sent and wraps from 0xFF to 0x00. Otherwise it changes only when a byte address is written.
- R7: The pointer survives a stop. A read with no address write continues from it, and a transaction that was not acknowledged leaves it unchanged.
- R8: After the master answers a data byte with no acknowledge (SDA high on the 9th clock), the block releases SDA and keeps it released until a start or a stop.
- R9: The SDA drive enable changes only while the synchronised SCL is low.
- R10: The byte stored at address a is {a[3:0], a[7:4]} XOR 0x5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | When 1, pull SDA low; when 0, release SDA |

## Verification
A start or stop event and the per-bit work of the current state can arrive in the same system-clock cycle. In that cycle the bus event must win over the state's own transition. The clearest case is the repeated start that follows the byte-address acknowledge in a random read. The bench issues it right after PTR_ACK. The read that follows must return the byte at the newly written address, not garbage from the old pointer or a missed start. A second case is a start issued while the block sits in IGNORE after a mismatching address: the next matching read must be acknowledged and must return data from the unchanged pointer.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl & scl_d;
    // SDA edges while SCL stays high frame a transaction
    assign bus_start = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign bus_stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_ptr_rom.sv
module i2c_ptr_rom #(
    parameter int          AW   = 8,
    parameter int          DW   = 8,
    parameter logic [7:0]  SALT = 8'h5A
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int HALF = AW / 2;

    // Content is a nibble swap of the address mixed with a constant
    always_ff @(posedge clk) begin
        rd_data <= DW'({rd_addr[HALF-1:0], rd_addr[AW-1:HALF]}) ^ DW'(SALT);
    end

endmodule

// File: rtl/i2c_ptr_mem_target.sv
module i2c_ptr_mem_target
    import i2c_ptr_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h50,
    parameter int         AW          = 8,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int CW = $clog2(DW + 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;

    tgt_state_e    state, state_n;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] rx_sh;
    logic [DW-1:0] tx_sh;
    logic [DW-1:0] rom_q;
    logic [AW-1:0] ptr;
    logic          m_ack;
    logic          addr_hit;
    logic          rd_mode;
    logic          byte_in_done;
    logic          tx_last;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_ptr_rom #(.AW(AW), .DW(DW)) u_rom (
        .clk     (clk),
        .rd_addr (ptr),
        .rd_data (rom_q)
    );

    assign addr_hit     = (rx_sh[DW-1:1] == TARGET_ADDR);
    assign rd_mode      = rx_sh[0];
    assign byte_in_done = scl_fall && (bit_cnt == CW'(DW));
    assign tx_last      = scl_fall && (bit_cnt == CW'(DW - 1));

    // Next-state logic: bus events override per-bit progress
    always_comb begin
        state_n = state;
        if (bus_stop) begin
            state_n = ST_IDLE;
        end else if (bus_start) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (byte_in_done) state_n = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_n = rd_mode ? ST_TX : ST_PTR;
                ST_PTR:      if (byte_in_done) state_n = ST_PTR_ACK;
                ST_PTR_ACK:  if (scl_fall) state_n = ST_IGNORE;
                ST_TX:       if (tx_last) state_n = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_n = m_ack ? ST_TX : ST_IGNORE;
                ST_IGNORE:   state_n = ST_IGNORE;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Datapath and SDA drive; SDA only moves on a falling SCL edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ptr     <= '0;
            m_ack   <= 1'b0;
        end else if (bus_stop || bus_start) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR: begin
                    if (scl_rise && (bit_cnt < CW'(DW))) begin
                        rx_sh   <= {rx_sh[DW-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_in_done) begin
                        bit_cnt <= '0;
                        if (state == ST_PTR) begin
                            ptr    <= AW'(rx_sh);
                            sda_oe <= 1'b1;
                        end else if (addr_hit) begin
                            sda_oe <= 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        if (rd_mode) begin
                            tx_sh   <= rom_q;
                            sda_oe  <= ~rom_q[DW-1];
                            ptr     <= ptr + 1'b1;
                            bit_cnt <= '0;
                        end
                    end
                end
                ST_PTR_ACK: begin
                    if (scl_fall) sda_oe <= 1'b0;
                end
                ST_TX: begin
                    if (tx_last) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                    end else if (scl_fall) begin
                        sda_oe  <= ~tx_sh[DW-2];
                        tx_sh   <= {tx_sh[DW-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) m_ack <= ~sda_lvl;
                    if (scl_fall && m_ack) begin
                        tx_sh   <= rom_q;
                        sda_oe  <= ~rom_q[DW-1];
                        ptr     <= ptr + 1'b1;
                        bit_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: drive enable moves only while SCL is low
    p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // R2: address acknowledge holds SDA low
    p_addr_ack_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> sda_oe);

    // R8: quiet after a refused address or a final NACK
    p_ignore_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // R8: SDA released while master answers a data byte
    p_tx_ack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK) |-> !sda_oe);

    // R6: outside pointer load, pointer only steps by one (with wrap)
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr != $past(ptr)) && ($past(state) != ST_PTR)) |-> (ptr == AW'($past(ptr) + 1)));

endmodule

// File: tb/i2c_ptr_mem_target_bench.sv
module i2c_ptr_mem_target_bench;

    localparam int         Q    = 10;
    localparam logic [6:0] DEVA = 7'h50;

    // {random(1)/current(0), start pointer, byte count}
    localparam logic [16:0] VEC [0:5] = '{
        {1'b1, 8'h10, 8'd1},
        {1'b1, 8'h3C, 8'd4},
        {1'b0, 8'h00, 8'd3},
        {1'b1, 8'hFE, 8'd4},
        {1'b0, 8'h00, 8'd2},
        {1'b1, 8'h80, 8'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;
    logic [7:0] exp_ptr = 8'h00;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_ptr_mem_target u_i2c_ptr_mem_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    function automatic logic [7:0] ref_byte(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic nack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(nack);
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~give_ack);
    endtask

    task automatic read_burst(input int cnt, input string req);
        logic [7:0] d;
        logic       nk;
        put_byte({DEVA, 1'b1}, nk);
        chk("R2 read address ack", {7'd0, nk}, 8'd0);
        for (int i = 0; i < cnt; i++) begin
            get_byte(i < cnt - 1, d);
            chk(req, d, ref_byte(exp_ptr));
            exp_ptr = exp_ptr + 8'd1;
        end
        chk("R8 SDA released after NACK", {7'd0, sda_oe}, 8'd0);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic nk;
        bus_start();
        put_byte({DEVA, 1'b0}, nk);
        chk("R2 write address ack", {7'd0, nk}, 8'd0);
        put_byte(p, nk);
        chk("R3 byte address ack", {7'd0, nk}, 8'd0);
        exp_ptr = p;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       nk;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 SDA released after reset", {7'd0, sda_oe}, 8'd0);

        // R1 R7: first current-address read starts at 0x00
        bus_start();
        read_burst(2, "R1 R7 current read from reset pointer");
        bus_stop();

        // table of transactions
        for (int v = 0; v < 6; v++) begin
            if (VEC[v][16]) begin
                set_ptr(VEC[v][15:8]);
                bus_start();
                read_burst(int'(VEC[v][7:0]), "R4 R5 R6 R10 random/sequential read");
            end else begin
                bus_start();
                read_burst(int'(VEC[v][7:0]), "R7 R5 current-address read");
            end
            bus_stop();
        end

        // R2: mismatching address is refused and the bus stays released
        bus_start();
        put_byte({7'h23, 1'b1}, nk);
        chk("R2 mismatch not acknowledged", {7'd0, nk}, 8'd1);
        get_byte(1'b1, d);
        chk("R2 no drive after mismatch", d, 8'hFF);
        // repeated start recovers; pointer untouched (R7)
        bus_start();
        read_burst(1, "R7 pointer unchanged by refused transaction");
        bus_stop();

        // R6: wrap through 0xFF with a fresh random read
        set_ptr(8'hFF);
        bus_start();
        read_burst(3, "R6 wrap FF to 00");
        bus_stop();

        // R8: after NACK the block stays off the bus for extra clocks
        bus_start();
        read_burst(1, "R4 single byte");
        get_byte(1'b1, d);
        chk("R8 quiet after NACK", d, 8'hFF);
        bus_stop();
        bus_start();
        read_burst(1, "R7 R8 pointer after quiet clocks");
        bus_stop();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule